// File: doc/BRIEF.md
# Output Voltage Supervisor with Deglitch

This block supervises the output of a boost regulator. It takes digital flags from analog comparators: an undervoltage flag, an overvoltage flag and a zero-current flag. It also takes an enable/input-undervoltage-good flag, a bias-rail-good flag, an over-temperature flag and the light-load switching mode. From these it drives an active-low request for the open-drain power-good pulldown, and it drives the overvoltage response for the gate-driver stage.

The undervoltage flag is filtered before it reaches power-good. The filter has one settle time for the output becoming good and a shorter one for the output going bad, and a flag that bounces restarts the count. The other fault inputs pull power-good low on the next clock with no filtering. The comparator thresholds and their hysteresis sit in the analog front end: undervoltage trips at about 94% of target rising and 92% falling, and overvoltage at about 108% rising and 105% falling. They reach this block only as flags.

On overvoltage in skip or diode-emulation mode, the low-side switch is blocked and the high-side switch is held on until zero current is reported. In forced-PWM mode the switches are left to normal control. If overvoltage stays present long enough, the block requests deep sleep and holds the high-side switch fully on. All times are counted in pulses of a timebase tick input. Every pin is plain control or status; there is no streaming interface.

Top module: `vout_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pg_od_o`, `ls_block_o`, `hs_force_o` and `sleep_req_o` are all 0 after that edge, and the undervoltage filter restarts in the "not good" state.
- R2: `pg_od_o` is 1 (pulldown released) only when the filtered output-good state is 1 and, at the previous clock edge, `en_ok_i` and `bias_ok_i` were 1 and `otemp_i` was 0. It is a register updated on every clock.
- R3: With the filter in the "not good" state, `uv_i`=0 must be seen on 26 consecutive tick edges (default timing) before the filtered state becomes good. `pg_od_o` rises one clock after that 26th tick edge.
- R4: With the filter in the "good" state, `uv_i`=1 must be seen on 21 consecutive tick edges before the filtered state goes bad. `pg_od_o` falls one clock after that 21st tick edge.
- R5: If `uv_i` returns to the filtered state at any clock edge before the count expires, the count restarts from zero. The filtered state changes only at clock edges where `tick_i` is 1.
- R6: Dropping `en_ok_i` or `bias_ok_i`, or raising `otemp_i`, makes `pg_od_o` 0 after the next clock edge with no filtering. Removing the fault restores `pg_od_o` on the next clock edge, and the undervoltage filter state is not disturbed.
- R7: In skip (`mode_i`=2'b00) or diode-emulation (`mode_i`=2'b01) mode, a rising `ov_i` sets `ls_block_o` and `hs_force_o` to 1 after the next clock edge. Both clear after the edge at which `zc_i`=1 or `ov_i`=0.
- R8: In forced-PWM mode (`mode_i`=2'b10, and 2'b11 treated alike), overvoltage does not raise `ls_block_o` or `hs_force_o` before the deep-sleep escalation.
- R9: When `ov_i` is 1 on 40 consecutive tick edges (default timing), `sleep_req_o`, `hs_force_o` and `ls_block_o` all become 1 after the 40th tick edge, in any mode. They clear after the first clock edge with `ov_i`=0.
- R10: Any clock edge with `ov_i`=0 clears the overvoltage timer. An overvoltage that lasts 39 tick edges never raises `sleep_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase pulse, one clock wide |
| uv_i | input | 1 | 1 = output below undervoltage threshold |
| ov_i | input | 1 | 1 = output above overvoltage threshold |
| zc_i | input | 1 | 1 = zero inductor current detected |
| en_ok_i | input | 1 | 1 = enable/input undervoltage check good |
| bias_ok_i | input | 1 | 1 = bias rail above its lockout level |
| otemp_i | input | 1 | 1 = thermal shutdown active |
| mode_i | input | 2 | Light-load mode: 00 skip, 01 diode emulation, 1x forced PWM |
| pg_od_o | output | 1 | Active-low pulldown request: 0 = pull power-good low |
| ls_block_o | output | 1 | 1 = force low-side switch off |
| hs_force_o | output | 1 | 1 = hold high-side switch on |
| sleep_req_o | output | 1 | 1 = request deep sleep |

## Verification
The undervoltage filter is driven with a clean rise held just one tick short and then to its full count, which tells the 26-tick rise time apart from the 21-tick fall time. A bad period broken by a one-edge glitch just before expiry shows that the count restarts rather than accumulates. Each non-filtered fault is pulsed on its own while the output is good, which shows both the immediate pulldown and that the filter state survives. Overvoltage is applied in diode-emulation, skip and forced-PWM modes to separate the mode-dependent clamp and its release by zero current or by the flag clearing. A 39-tick overvoltage, a break, then a 40-tick overvoltage separates a timer that restarts from one that accumulates.

// File: rtl/vsup_pkg.sv
package vsup_pkg;

  typedef enum logic [1:0] {
    MODE_SKIP  = 2'b00,
    MODE_DIODE = 2'b01,
    MODE_FPWM  = 2'b10,
    MODE_FPWM2 = 2'b11
  } ll_mode_e;

  // Round a duration up to whole tick periods, never less than one.
  function automatic int dur_to_ticks(int dur_ns, int tick_ns);
    int t;
    t = (dur_ns + tick_ns - 1) / tick_ns;
    return (t < 1) ? 1 : t;
  endfunction

  function automatic logic is_fpwm(logic [1:0] m);
    return (m == MODE_FPWM) || (m == MODE_FPWM2);
  endfunction

endpackage

// File: rtl/vsup_deglitch.sv
module vsup_deglitch #(
  parameter int RISE_TICKS = 26,
  parameter int FALL_TICKS = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  output logic filt_o
);
  localparam int MAXT = (RISE_TICKS > FALL_TICKS) ? RISE_TICKS : FALL_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_TICKS - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;
  logic [CW-1:0] last;

  // Going good uses the rise time, going bad the fall time.
  assign last = filt_q ? FALL_LAST : RISE_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == last) begin
        filt_q <= raw_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(filt_q));

  a_r3_moves_toward_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(raw_i)));

endmodule

// File: rtl/vsup_ov_guard.sv
module vsup_ov_guard #(
  parameter int SLEEP_TICKS = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ov_i,
  input  logic       zc_i,
  input  logic [1:0] mode_i,
  output logic       ls_block_o,
  output logic       hs_force_o,
  output logic       sleep_o
);
  import vsup_pkg::*;

  localparam int TW = $clog2(SLEEP_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(SLEEP_TICKS - 1);

  logic [TW-1:0] tmr_q;
  logic          sleep_q;
  logic          ov_d_q;
  logic          clamp_q;
  logic          fpwm;

  assign fpwm = is_fpwm(mode_i);

  // Sustained-fault timer: counts ticks while overvoltage is present.
  always_ff @(posedge clk) begin
    if (!rst_n || !ov_i) begin
      tmr_q   <= '0;
      sleep_q <= 1'b0;
    end else if (tick_i && !sleep_q) begin
      if (tmr_q == LAST) sleep_q <= 1'b1;
      else               tmr_q   <= tmr_q + 1'b1;
    end
  end

  // Clamp: armed on the overvoltage edge, released by zero current.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_d_q  <= 1'b0;
      clamp_q <= 1'b0;
    end else begin
      ov_d_q <= ov_i;
      if (!ov_i || fpwm)       clamp_q <= 1'b0;
      else if (!ov_d_q)        clamp_q <= 1'b1;
      else if (zc_i)           clamp_q <= 1'b0;
    end
  end

  assign ls_block_o = (clamp_q && !fpwm) || sleep_q;
  assign hs_force_o = (clamp_q && !fpwm) || sleep_q;
  assign sleep_o    = sleep_q;

  a_r7_clamp_from_ov_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_q) |-> ($past(ov_i) && !$past(ov_d_q)));

  a_r10_sleep_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> ($past(tick_i) && $past(ov_i)));

  a_r9_sleep_drops_with_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && !ov_i) |=> !sleep_q);

endmodule

// File: rtl/vout_supervisor.sv
module vout_supervisor #(
  parameter int TICK_NS     = 1000,
  parameter int UV_RISE_NS  = 26000,
  parameter int UV_FALL_NS  = 21000,
  parameter int OV_SLEEP_NS = 40000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       uv_i,
  input  logic       ov_i,
  input  logic       zc_i,
  input  logic       en_ok_i,
  input  logic       bias_ok_i,
  input  logic       otemp_i,
  input  logic [1:0] mode_i,
  output logic       pg_od_o,
  output logic       ls_block_o,
  output logic       hs_force_o,
  output logic       sleep_req_o
);
  import vsup_pkg::*;

  localparam int RISE_T  = dur_to_ticks(UV_RISE_NS, TICK_NS);
  localparam int FALL_T  = dur_to_ticks(UV_FALL_NS, TICK_NS);
  localparam int SLEEP_T = dur_to_ticks(OV_SLEEP_NS, TICK_NS);

  logic good_filt;
  logic rails_ok;
  logic pg_q;

  vsup_deglitch #(
    .RISE_TICKS(RISE_T),
    .FALL_TICKS(FALL_T)
  ) u_uv_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_i(tick_i),
    .raw_i (!uv_i),
    .filt_o(good_filt)
  );

  vsup_ov_guard #(
    .SLEEP_TICKS(SLEEP_T)
  ) u_ov_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .ov_i      (ov_i),
    .zc_i      (zc_i),
    .mode_i    (mode_i),
    .ls_block_o(ls_block_o),
    .hs_force_o(hs_force_o),
    .sleep_o   (sleep_req_o)
  );

  assign rails_ok = en_ok_i && bias_ok_i && !otemp_i;

  always_ff @(posedge clk) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= good_filt && rails_ok;
  end

  assign pg_od_o = pg_q;

  a_r6_fault_pulls_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ok_i || !bias_ok_i || otemp_i) |=> !pg_od_o);

  a_r2_release_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    pg_od_o |-> $past(good_filt));

endmodule

// File: tb/test_vout_supervisor.sv
`timescale 1ns/1ps
module test_vout_supervisor;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic uv = 1'b0, ov = 1'b0, zc = 1'b0;
  logic en_ok = 1'b1, bias_ok = 1'b1, otemp = 1'b0;
  logic [1:0] mode = 2'b01;
  logic pg_od, ls_block, hs_force, sleep_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vout_supervisor i_vout_supervisor (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .uv_i(uv), .ov_i(ov), .zc_i(zc),
    .en_ok_i(en_ok), .bias_ok_i(bias_ok), .otemp_i(otemp), .mode_i(mode),
    .pg_od_o(pg_od), .ls_block_o(ls_block), .hs_force_o(hs_force),
    .sleep_req_o(sleep_req)
  );

  // Timebase: one-clock pulse every fourth clock.
  initial begin
    forever begin
      repeat (3) @(posedge clk);
      tick <= 1'b1;
      @(posedge clk);
      tick <= 1'b0;
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (tick !== 1'b1);
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic next_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    next_edge();
    check("R1 pg in reset", pg_od, 1'b0);
    check("R1 ls in reset", ls_block, 1'b0);
    check("R1 hs in reset", hs_force, 1'b0);
    check("R1 sleep in reset", sleep_req, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_rise();
    wait_ticks(25);
    next_edge();
    check("R3 pg held after 25 ticks", pg_od, 1'b0);
    wait_tick();
    next_edge();
    check("R3 pg released after 26 ticks", pg_od, 1'b1);
    check("R2 release with all good", pg_od, 1'b1);
  endtask

  task automatic t_fall_glitch();
    uv = 1'b1;
    wait_ticks(20);
    #1 uv = 1'b0;
    @(posedge clk); @(posedge clk);
    #1 uv = 1'b1;
    wait_ticks(20);
    next_edge();
    check("R5 count restarted by glitch", pg_od, 1'b1);
    wait_tick();
    next_edge();
    check("R4 pulldown after 21 ticks", pg_od, 1'b0);
    uv = 1'b0;
    wait_ticks(26);
    next_edge();
    check("R3 pg back after recovery", pg_od, 1'b1);
  endtask

  task automatic t_rail_faults();
    bias_ok = 1'b0;
    next_edge();
    check("R6 bias fault immediate", pg_od, 1'b0);
    bias_ok = 1'b1;
    next_edge();
    check("R6 bias recovery keeps filter", pg_od, 1'b1);
    otemp = 1'b1;
    next_edge();
    check("R6 thermal fault immediate", pg_od, 1'b0);
    otemp = 1'b0;
    en_ok = 1'b0;
    next_edge();
    check("R6 enable fault immediate", pg_od, 1'b0);
    en_ok = 1'b1;
    next_edge();
    check("R2 release after faults clear", pg_od, 1'b1);
  endtask

  task automatic t_ov_clamp();
    mode = 2'b01;
    ov = 1'b1;
    next_edge();
    check("R7 diode ls blocked", ls_block, 1'b1);
    check("R7 diode hs forced", hs_force, 1'b1);
    repeat (3) next_edge();
    check("R7 clamp held before zc", hs_force, 1'b1);
    zc = 1'b1;
    next_edge();
    check("R7 zc releases ls", ls_block, 1'b0);
    check("R7 zc releases hs", hs_force, 1'b0);
    zc = 1'b0;
    ov = 1'b0;
    next_edge();
    mode = 2'b00;
    ov = 1'b1;
    next_edge();
    check("R7 skip ls blocked", ls_block, 1'b1);
    ov = 1'b0;
    next_edge();
    check("R7 ov clear releases hs", hs_force, 1'b0);
  endtask

  task automatic t_ov_fpwm();
    mode = 2'b10;
    ov = 1'b1;
    next_edge();
    check("R8 fpwm no ls block", ls_block, 1'b0);
    wait_ticks(10);
    #1;
    check("R8 fpwm no hs force", hs_force, 1'b0);
    ov = 1'b0;
    next_edge();
  endtask

  task automatic t_ov_sleep();
    mode = 2'b10;
    ov = 1'b1;
    wait_ticks(39);
    #1;
    check("R10 no sleep at 39 ticks", sleep_req, 1'b0);
    ov = 1'b0;
    next_edge();
    ov = 1'b1;
    wait_ticks(39);
    #1;
    check("R10 timer restarted", sleep_req, 1'b0);
    wait_tick();
    #1;
    check("R9 sleep after 40 ticks", sleep_req, 1'b1);
    check("R9 hs full on", hs_force, 1'b1);
    check("R9 ls blocked in sleep", ls_block, 1'b1);
    ov = 1'b0;
    next_edge();
    check("R9 sleep clears with ov", sleep_req, 1'b0);
    check("R9 hs released", hs_force, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_rise();
    t_fall_glitch();
    t_rail_faults();
    t_ov_clamp();
    t_ov_fpwm();
    t_ov_sleep();
    finish_run();
  end

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule